// File: doc/BRIEF.md
# Command List Register Writer

This block walks a list of commands stored in a word-addressed memory and turns each one into masked register writes on an internal register file. Software places the list in memory, then pulses `start` with the word address of the first entry and the list length in words. The block holds `busy` high while it fetches. When the list is used up it drops `busy` and pulses `done` for one cycle.

Every command occupies two words. The payload word comes first and the header word second. The header names a target register, a four-bit byte-lane mask, a number of extra payload words, and a flag that selects one of two burst styles. With the flag clear, all the payload words go to the same register. With the flag set, the payload words go to consecutive registers. Each write is a read-modify-write that replaces only the enabled byte lanes. Each write is reported by a strobe together with the register index and the new value, and software can use that strobe to trigger side effects. A write aimed past the end of the register file is dropped and raises a one-cycle error pulse. A separate combinational read port exposes the register file.

The memory read port has a latency of one cycle. A command pair takes three cycles. Each extra payload word takes one more cycle.

Top module: `gpu_cmd_writer`

## Requirements
- R1: After reset, `busy`, `done`, `wr_stb` and `err` are low, and every register reads zero.
- R2: While the block is idle, a `start` pulse captures `list_base` and `list_len` and raises `busy`. `busy` stays high until the list is exhausted, and then `done` pulses for exactly one cycle while `busy` is low. A `start` pulse that arrives while `busy` is high is ignored.
- R3: A command is a payload word followed by a header word. In the header, bits [15:0] hold the register index, bits [19:16] hold the byte mask, bits [30:20] hold the number of extra payload words, and bit 31 is the grouping flag.
- R4: Mask bit n enables byte lane n, which is data bits [8n+7:8n]. For example, mask 4'b0101 enables the lanes covered by 32'h00FF00FF. The new register value is (old & ~lanes) | (payload & lanes).
- R5: Before a command pair is fetched, the read pointer moves forward one word if its distance from `list_base` is odd. Every pair therefore starts at an even offset from the list base.
- R6: With the grouping flag clear, the first payload word and every extra payload word are all written to the header's register index, in list order.
- R7: With the grouping flag set, extra payload word i (counting from 0) is written to the header's index plus i+1.
- R8: The header's mask applies to every write of that command, including all extra payload words.
- R9: A write whose index is 1024 or more changes no register, produces no `wr_stb`, and pulses `err` for one cycle.
- R10: Fetching stops as soon as the aligned read pointer reaches `list_base + list_len`. A length of zero produces `done` with no write. Words beyond the end are never executed as commands.
- R11: Each accepted write pulses `wr_stb` for one cycle. In that cycle `wr_id` carries the register index and `wr_value` carries the value now held by that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking a list (used only when idle) |
| list_base | input | 16 | Word address of the first list word |
| list_len | input | 16 | List length in words |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | High while a list is being walked |
| done | output | 1 | One-cycle pulse when the list is exhausted |
| wr_stb | output | 1 | One-cycle pulse for each accepted register write |
| wr_id | output | 16 | Index of the register just written |
| wr_value | output | 32 | New value of the register just written |
| err | output | 1 | One-cycle pulse for a dropped out-of-range write |
| dbg_addr | input | 10 | Register file read index |
| dbg_data | output | 32 | Register file read data (combinational) |

## Verification
The two functions that collide are the read half of one read-modify-write and the write half of the previous one. In an ungrouped burst, consecutive words hit the same register on consecutive cycles, so each merge reads the value that was stored only one edge earlier. The bench provokes this with directed bursts that use partial masks and with random lists that contain repeat counts and mixed masks. It judges the result by comparing every strobe and the final contents of the register file against a bench model that applies the writes one after another.

// File: rtl/gpu_cmd_writer.sv
module gpu_cmd_writer #(
  parameter int NREG = 1024,
  parameter int AW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] list_base,
  input  logic [AW-1:0] list_len,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          wr_stb,
  output logic [15:0]   wr_id,
  output logic [31:0]   wr_value,
  output logic          err,
  input  logic [RW-1:0] dbg_addr,
  output logic [31:0]   dbg_data
);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DAT, S_HDR, S_EXT} st_t;
  st_t st;

  logic [AW:0]   ptr, base_q, end_q, aptr;
  logic [31:0]   data_q;
  logic [3:0]    mask_q;
  logic [10:0]   cnt_q;
  logic          grp_q;
  logic [16:0]   id_q;
  logic [31:0]   regs [NREG];

  logic          odd, stop, do_wr, inr;
  logic [16:0]   w_id;
  logic [31:0]   w_data, lanes, old_v, new_v;
  logic [3:0]    w_mask;

  assign odd    = ptr[0] ^ base_q[0];
  assign aptr   = ptr + {{AW{1'b0}}, odd};
  assign stop   = aptr >= end_q;
  assign busy   = st != S_IDLE;
  assign mem_rd = (st == S_CMD && !stop) || st == S_DAT ||
                  (st == S_HDR && mem_rdata[30:20] != 11'd0) ||
                  (st == S_EXT && cnt_q > 11'd1);
  assign mem_addr = (st == S_CMD) ? aptr[AW-1:0] : ptr[AW-1:0];

  assign do_wr  = st == S_HDR || st == S_EXT;
  assign w_id   = (st == S_HDR) ? {1'b0, mem_rdata[15:0]} : (grp_q ? id_q + 17'd1 : id_q);
  assign w_data = (st == S_HDR) ? data_q : mem_rdata;
  assign w_mask = (st == S_HDR) ? mem_rdata[19:16] : mask_q;
  assign inr    = w_id < 17'(NREG);

  for (genvar n = 0; n < 4; n++) begin : g_lane
    assign lanes[8*n +: 8] = {8{w_mask[n]}};
  end

  assign old_v    = regs[w_id[RW-1:0]];
  assign new_v    = (old_v & ~lanes) | (w_data & lanes);
  assign dbg_data = regs[dbg_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; base_q <= '0; end_q <= '0;
      data_q <= '0; mask_q <= '0; cnt_q <= '0; grp_q <= 1'b0; id_q <= '0;
      done <= 1'b0; wr_stb <= 1'b0; err <= 1'b0; wr_id <= '0; wr_value <= '0;
    end else begin
      done     <= 1'b0;
      wr_stb   <= do_wr && inr;
      err      <= do_wr && !inr;
      wr_id    <= w_id[15:0];
      wr_value <= new_v;
      case (st)
        S_IDLE: if (start) begin
          base_q <= {1'b0, list_base};
          ptr    <= {1'b0, list_base};
          end_q  <= {1'b0, list_base} + {1'b0, list_len};
          st     <= S_CMD;
        end
        S_CMD: if (stop) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          ptr <= aptr + 1'b1;
          st  <= S_DAT;
        end
        S_DAT: begin
          data_q <= mem_rdata;
          ptr    <= ptr + 1'b1;
          st     <= S_HDR;
        end
        S_HDR: begin
          id_q   <= {1'b0, mem_rdata[15:0]};
          mask_q <= mem_rdata[19:16];
          cnt_q  <= mem_rdata[30:20];
          grp_q  <= mem_rdata[31];
          if (mem_rdata[30:20] != 11'd0) begin
            ptr <= ptr + 1'b1;
            st  <= S_EXT;
          end else st <= S_CMD;
        end
        S_EXT: begin
          cnt_q <= cnt_q - 11'd1;
          if (grp_q) id_q <= id_q + 17'd1;
          if (cnt_q > 11'd1) ptr <= ptr + 1'b1;
          else st <= S_CMD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (do_wr && inr) begin
      regs[w_id[RW-1:0]] <= new_v;
    end
  end

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_CMD) |=> $stable(base_q));
  a_r9_err_no_stb: assert property (@(posedge clk) disable iff (!rst_n) err |-> !wr_stb);
  a_r11_stb_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_id < 16'(NREG));
  a_r5_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DAT) |-> (ptr[0] != base_q[0]));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_rd);

endmodule

// File: tb/sim_gpu_cmd_writer.sv
module sim_gpu_cmd_writer;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] list_base = 0, list_len = 0;
  logic mem_rd, busy, done, wr_stb, err;
  logic [15:0] mem_addr, wr_id;
  logic [31:0] mem_rdata, wr_value, dbg_data;
  logic [9:0] dbg_addr = 0;

  always #2.5 clk = ~clk;

  gpu_cmd_writer u0 (.clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .list_len(list_len), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .wr_stb(wr_stb), .wr_id(wr_id), .wr_value(wr_value),
    .err(err), .dbg_addr(dbg_addr), .dbg_data(dbg_data));

  logic [31:0] mem [0:511];
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];

  int total = 0, fails = 0, cyc = 0;
  logic [31:0] exp_reg [0:1023];
  logic [31:0] eid [0:4095];
  logic [31:0] evl [0:4095];
  int n_exp, n_got, n_err_exp, n_err_got;
  string tag = "R11";

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] ex);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, ex);
    end
  endtask

  function automatic logic [31:0] hdr(input int id, input logic [3:0] m, input int cnt, input bit g);
    return {g, 11'(cnt), m, 16'(id)};
  endfunction

  task automatic model_write(input int id, input logic [31:0] d, input logic [3:0] m);
    logic [31:0] ln;
    if (id >= 1024) n_err_exp++;
    else begin
      for (int n = 0; n < 4; n++) ln[8*n +: 8] = {8{m[n]}};
      exp_reg[id] = (exp_reg[id] & ~ln) | (d & ln);
      eid[n_exp] = id; evl[n_exp] = exp_reg[id]; n_exp++;
    end
  endtask

  task automatic model_list(input int base, input int len);
    int p = base;
    logic [31:0] d, h;
    while (1) begin
      if ((p - base) % 2 != 0) p++;
      if (p >= base + len) break;
      d = mem[p % 512]; h = mem[(p + 1) % 512]; p += 2;
      model_write(int'(h[15:0]), d, h[19:16]);
      for (int i = 0; i < int'(h[30:20]); i++) begin
        model_write(h[31] ? int'(h[15:0]) + i + 1 : int'(h[15:0]), mem[p % 512], h[19:16]);
        p++;
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin
      check(n_got < n_exp && {16'd0, wr_id} == eid[n_got] && wr_value == evl[n_got],
            tag, {wr_id, wr_value[15:0]}, {eid[n_got][15:0], evl[n_got][15:0]});
      n_got++;
    end
    if (err) n_err_got++;
  end

  task automatic kick(input int base, input int len);
    @(negedge clk);
    list_base = 16'(base); list_len = 16'(len); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string t);
    int k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    check(done && !busy, {t, " done"}, {30'd0, done, busy}, 32'h2);
  endtask

  task automatic cmp_regs(input string t);
    int bad = 0;
    logic [31:0] a = 0, e = 0;
    for (int i = 0; i < 1024; i++) begin
      dbg_addr = 10'(i); #0.01;
      if (dbg_data !== exp_reg[i]) begin if (bad == 0) begin a = dbg_data; e = exp_reg[i]; end bad++; end
    end
    check(bad == 0, {t, " regfile"}, a, e);
  endtask

  task automatic run_list(input int base, input int len, input string t);
    n_exp = 0; n_got = 0; n_err_exp = 0; n_err_got = 0; tag = t;
    model_list(base, len);
    kick(base, len);
    wait_done(t);
    @(negedge clk);
    check(n_got == n_exp, {t, " strobe count"}, n_got, n_exp);
    check(n_err_got == n_err_exp, "R9 err count", n_err_got, n_err_exp);
    cmp_regs(t);
  endtask

  task automatic peek(input int id, input logic [31:0] e, input string t);
    dbg_addr = 10'(id); #0.01;
    check(dbg_data == e, t, dbg_data, e);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    for (int i = 0; i < 1024; i++) exp_reg[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !wr_stb && !err, "R1 outputs", {busy, done, wr_stb, err}, 0);
    peek(0, 0, "R1 reg0");
    peek(1023, 0, "R1 reg1023");

    // R3/R4: payload then header, lane masks
    mem[0] = 32'hAABBCCDD; mem[1] = hdr(5, 4'b0101, 0, 0);
    run_list(0, 2, "R3");
    peek(5, 32'h00BB00DD, "R4 mask0101");
    mem[10] = 32'h11223344; mem[11] = hdr(5, 4'b1010, 0, 0);
    run_list(10, 2, "R4");
    peek(5, 32'h11BB33DD, "R4 mask1010");

    // R5: alignment with even and odd list base
    mem[20] = 32'h1; mem[21] = hdr(7, 4'hF, 1, 0); mem[22] = 32'h77; mem[23] = 32'hDEADBEEF;
    mem[24] = 32'h88; mem[25] = hdr(8, 4'hF, 0, 0);
    run_list(20, 6, "R5");
    peek(8, 32'h88, "R5 even base");
    mem[31] = 32'h2; mem[32] = hdr(9, 4'hF, 1, 0); mem[33] = 32'h99; mem[34] = 32'hDEADBEEF;
    mem[35] = 32'hAA; mem[36] = hdr(10, 4'hF, 0, 0);
    run_list(31, 6, "R5");
    peek(10, 32'hAA, "R5 odd base");
    peek(9, 32'h99, "R6 repeated id");

    // R7 grouped burst
    mem[40] = 32'hD0; mem[41] = hdr(100, 4'hF, 3, 1); mem[42] = 32'hA1; mem[43] = 32'hB2; mem[44] = 32'hC3;
    run_list(40, 5, "R7");
    peek(100, 32'hD0, "R7 first");
    peek(103, 32'hC3, "R7 id+3");

    // R6/R8 ungrouped burst, partial mask, back-to-back RMW
    mem[50] = 32'hABCDEF01; mem[51] = hdr(200, 4'hF, 0, 0);
    mem[52] = 32'h11111111; mem[53] = hdr(200, 4'b0011, 1, 0); mem[54] = 32'h22222222;
    run_list(50, 5, "R8");
    peek(200, 32'hABCD2222, "R8 mask across burst");

    // R9 out of range, alone and at end of grouped burst
    mem[60] = 32'h5; mem[61] = hdr(1024, 4'hF, 0, 0);
    mem[62] = 32'h6; mem[63] = hdr(1022, 4'hF, 2, 1); mem[64] = 32'h7; mem[65] = 32'h8;
    run_list(60, 6, "R9");
    check(n_err_got == 2, "R9 two errors", n_err_got, 2);
    peek(1023, 32'h7, "R9 last valid");

    // R10 zero length and stop at end
    run_list(70, 0, "R10");
    check(n_got == 0, "R10 zero length no write", n_got, 0);
    mem[80] = 32'h3; mem[81] = hdr(301, 4'hF, 0, 0); mem[82] = 32'h44; mem[83] = hdr(300, 4'hF, 0, 0);
    run_list(80, 2, "R10");
    peek(300, 0, "R10 beyond end untouched");

    // R2 start while busy is ignored
    mem[90] = 32'h5A; mem[91] = hdr(400, 4'hF, 2, 1); mem[92] = 32'h5B; mem[93] = 32'h5C;
    mem[100] = 32'hBAD; mem[101] = hdr(500, 4'hF, 0, 0);
    n_exp = 0; n_got = 0; n_err_exp = 0; n_err_got = 0; tag = "R2";
    model_list(90, 4);
    kick(90, 4);
    check(busy, "R2 busy", busy, 1);
    list_base = 100; list_len = 2; start = 1;
    @(negedge clk); start = 0;
    wait_done("R2");
    @(negedge clk);
    check(!done, "R2 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    check(!busy && n_got == 3, "R2 ignored start", n_got, 3);
    peek(500, 0, "R2 second list not run");
    cmp_regs("R2");

    // random lists
    for (int t = 0; t < 25; t++) begin
      int base = 120 + $urandom_range(0, 40);
      int p = base;
      while (p < base + $urandom_range(4, 60)) begin
        int c = $urandom_range(0, 3);
        int id = ($urandom_range(0, 9) == 0) ? $urandom_range(1018, 1030) : $urandom_range(0, 1023);
        if ((p - base) % 2 != 0) begin mem[p] = $urandom; p++; end
        mem[p] = $urandom; mem[p + 1] = hdr(id, 4'($urandom), c, 1'($urandom)); p += 2;
        for (int i = 0; i < c; i++) begin mem[p] = $urandom; p++; end
      end
      run_list(base, p - base, "R6");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule